// File: doc/BRIEF.md
# Interpolating Sine Oscillator

This block synthesizes a low-frequency sine for audio-rate use, such as the carrier of a voice ring modulator. On every sample strobe a 32-bit phase register advances by a tuning word. A 4-bit active-low switch input picks that word from sixteen presets between 12 Hz and 95 Hz. The top eight phase bits address a 256-entry full-cycle sine table, which is computed at elaboration. The next eight bits act as a fraction that blends linearly between the addressed entry and its neighbour.

With the blend, a slow tone moves a little on every sample instead of repeating one table value for several samples. A plain table lookup makes a staircase, and its steps are heard as a whine. The output is an unsigned 12-bit sample centred on 2048. The tone changes whenever the switches change, and the phase is never reset when that happens.

Top module: `dds_sine_interp`

## Requirements
- R1: After reset the phase is zero and `sample_o` reads 2048 (mid-scale).
- R2: Each cycle with `strobe_i` high adds the current tuning word to the phase, modulo 2^32. In cycles without a strobe, the phase and `sample_o` do not change.
- R3: The preset index is `~sw_ni`, so `sw_ni[0]` carries weight 1 and `sw_ni[3]` carries weight 8. In tenths of a hertz, indices 0 to 15 give 120, 145, 203, 256, 287, 300, 320, 428, 500, 600, 700, 750, 800, 850, 900 and 950. The tuning word is 1,523,800 times that tenths value, which is 15,238,000 per hertz.
- R4: Table entry i equals 2048 + 2048·sin(2πi/256), rounded half up and clamped to the range 0..4095.
- R5: With a = phase[31:24] and f = phase[23:16], the output is y0 + floor((y1 − y0)·f / 256). Here y0 is entry a and y1 is entry (a+1) mod 256.
- R6: The output that reflects the phase produced by a strobe taken at clock edge N appears on `sample_o` after edge N+2.
- R7: A change on `sw_ni` between strobes does not touch the phase. The new tuning word applies from the next strobe onward, so the tone stays phase-continuous.
- R8: Every output lies between y0 and y1 inclusive, so it never leaves 0..4095.
- R9: At address 255 the blend target wraps to entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Sample strobe, one cycle per output sample |
| sw_ni | input | 4 | Active-low preset select switches |
| sample_o | output | 12 | Unsigned sine sample, mid-scale 2048 |

## Verification
A strobe taken at edge N changes the phase at that edge. The table read is registered at edge N+1, and the blended sample is registered at edge N+2. The bench drives the strobe on a falling edge and drops it one cycle later. It then waits two more falling edges, so it reads `sample_o` half a cycle after edge N+2. The bench keeps its own model of the phase from the preset formula. It compares every sample against the blend formula applied to that phase. For the hold cases, it reads the output for several idle cycles after the switches change and before the next strobe.

// File: rtl/dds_pkg.sv
package dds_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // preset tone frequencies in 0.1 Hz units
  function automatic int preset_tenths(input int k);
    case (k)
      0:  return 120;
      1:  return 145;
      2:  return 203;
      3:  return 256;
      4:  return 287;
      5:  return 300;
      6:  return 320;
      7:  return 428;
      8:  return 500;
      9:  return 600;
      10: return 700;
      11: return 750;
      12: return 800;
      13: return 850;
      14: return 900;
      15: return 950;
      default: return 0;
    endcase
  endfunction

  function automatic int sine_entry(input int idx, input int depth, input int amp_w);
    real mid, ph, v;
    int  r, top;
    mid = real'(1 << (amp_w - 1));
    top = (1 << amp_w) - 1;
    ph  = TWO_PI * real'(idx) / real'(depth);
    v   = mid + mid * $sin(ph);
    r   = $rtoi(v + 0.5);
    if (r > top) r = top;
    if (r < 0) r = 0;
    return r;
  endfunction

endpackage

// File: rtl/dds_tune_sel.sv
module dds_tune_sel #(
  parameter int SEL_W   = 4,
  parameter int PHASE_W = 32,
  parameter int HZ_STEP = 15238000
) (
  input  logic [SEL_W-1:0]   sw_ni,
  output logic [PHASE_W-1:0] tw_o
);
  localparam int NUM_PRESET = 1 << SEL_W;

  logic [PHASE_W-1:0] tw_tab [NUM_PRESET];
  logic [SEL_W-1:0]   sel;

  for (genvar k = 0; k < NUM_PRESET; k++) begin : g_preset
    localparam logic [63:0] TW_L =
      64'(HZ_STEP) * 64'(dds_pkg::preset_tenths(k)) / 64'd10;
    assign tw_tab[k] = TW_L[PHASE_W-1:0];
  end

  assign sel  = ~sw_ni;
  assign tw_o = tw_tab[sel];

endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 8,
  parameter int FRAC_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic [PHASE_W-1:0] tw_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [FRAC_W-1:0]  frac_o
);
  localparam int TOP = PHASE_W - 1;

  logic [PHASE_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (step_i) acc_q <= acc_q + tw_i;
  end

  assign addr_o = acc_q[TOP -: ADDR_W];
  assign frac_o = acc_q[TOP-ADDR_W -: FRAC_W];

  AST_PHASE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(acc_q)); // R2
  AST_PHASE_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && tw_i != '0) |=> acc_q != $past(acc_q)); // R2

endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
  parameter int ADDR_W = 8,
  parameter int AMP_W  = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [AMP_W-1:0]  y0_o,
  output logic [AMP_W-1:0]  y1_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [AMP_W-1:0]  rom [DEPTH];
  logic [ADDR_W-1:0] addr_nx;

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    localparam int E = dds_pkg::sine_entry(i, DEPTH, AMP_W);
    assign rom[i] = E[AMP_W-1:0];
  end

  assign addr_nx = addr_i + 1'b1; // 255 -> 0
  assign y0_o    = rom[addr_i];
  assign y1_o    = rom[addr_nx];

endmodule

// File: rtl/dds_interp.sv
module dds_interp #(
  parameter int AMP_W  = 12,
  parameter int FRAC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              emit_i,
  input  logic [AMP_W-1:0]  y0_i,
  input  logic [AMP_W-1:0]  y1_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [AMP_W-1:0]  sample_o
);
  localparam int P = AMP_W + FRAC_W + 2;
  localparam logic [AMP_W-1:0] MID = {1'b1, {(AMP_W-1){1'b0}}};

  logic [AMP_W-1:0]  y0_q, y1_q, out_q;
  logic [FRAC_W-1:0] frac_q;
  logic signed [AMP_W:0] diff;
  logic signed [P-1:0]   prod, step, sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y0_q   <= MID;
      y1_q   <= MID;
      frac_q <= '0;
    end else if (load_i) begin
      y0_q   <= y0_i;
      y1_q   <= y1_i;
      frac_q <= frac_i;
    end
  end

  always_comb begin
    diff = $signed({1'b0, y1_q}) - $signed({1'b0, y0_q});
    prod = $signed({{(FRAC_W+1){diff[AMP_W]}}, diff})
         * $signed({{(AMP_W+2){1'b0}}, frac_q});
    step = prod >>> FRAC_W; // floor division
    sum  = $signed({{(P-AMP_W){1'b0}}, y0_q}) + step;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     out_q <= MID;
    else if (emit_i) out_q <= sum[AMP_W-1:0];
  end

  assign sample_o = out_q;

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !emit_i |=> $stable(out_q)); // R2
  AST_IN_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_i |=> ((out_q >= $past(y0_q) && out_q <= $past(y1_q)) ||
                (out_q <= $past(y0_q) && out_q >= $past(y1_q)))); // R8

endmodule

// File: rtl/dds_sine_interp.sv
module dds_sine_interp #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 8,
  parameter int FRAC_W  = 8,
  parameter int AMP_W   = 12,
  parameter int SEL_W   = 4,
  parameter int HZ_STEP = 15238000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic [SEL_W-1:0] sw_ni,
  output logic [AMP_W-1:0] sample_o
);
  logic [PHASE_W-1:0] tw;
  logic [ADDR_W-1:0]  addr;
  logic [FRAC_W-1:0]  frac;
  logic [AMP_W-1:0]   y0, y1;
  logic               strb_d1, strb_d2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_d1 <= 1'b0;
      strb_d2 <= 1'b0;
    end else begin
      strb_d1 <= strobe_i;
      strb_d2 <= strb_d1;
    end
  end

  dds_tune_sel #(.SEL_W(SEL_W), .PHASE_W(PHASE_W), .HZ_STEP(HZ_STEP)) u_sel (
    .sw_ni (sw_ni),
    .tw_o  (tw)
  );

  dds_phase_acc #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .FRAC_W(FRAC_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (strobe_i),
    .tw_i   (tw),
    .addr_o (addr),
    .frac_o (frac)
  );

  dds_sine_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom (
    .addr_i (addr),
    .y0_o   (y0),
    .y1_o   (y1)
  );

  dds_interp #(.AMP_W(AMP_W), .FRAC_W(FRAC_W)) u_interp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (strb_d1),
    .emit_i   (strb_d2),
    .y0_i     (y0),
    .y1_i     (y1),
    .frac_i   (frac),
    .sample_o (sample_o)
  );

  AST_PIPE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> strb_d1 ##1 strb_d2); // R6

endmodule

// File: tb/tb_dds_sine_interp.sv
`timescale 1ns/1ps
module tb_dds_sine_interp;

  localparam real TWO_PI = 6.283185307179586;
  localparam int  WDOG   = 190000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        strobe_i = 1'b0;
  logic [3:0]  sw_ni = 4'hF;
  logic [11:0] sample_o;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  logic [31:0] model_ph = '0;
  int last_exp = 2048;
  int hit_wrap = 0;

  int tenths [16] = '{120, 145, 203, 256, 287, 300, 320, 428,
                      500, 600, 700, 750, 800, 850, 900, 950};

  // {raw switch code, strobe count}
  localparam logic [11:0] VEC [10] = '{
    {4'hF, 8'd6},  {4'h0, 8'd9},  {4'hA, 8'd7},  {4'h5, 8'd11}, {4'hC, 8'd5},
    {4'h3, 8'd8},  {4'h7, 8'd10}, {4'hE, 8'd6},  {4'h1, 8'd12}, {4'h9, 8'd7}
  };

  dds_sine_interp dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe_i),
    .sw_ni    (sw_ni),
    .sample_o (sample_o)
  );

  always #2 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == WDOG) begin
      errors = errors + 1;
      $display("FAIL R6 watchdog: cycles %0d expected below %0d", cyc, WDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int exp_rom(input int i);
    real v;
    int  r;
    v = 2048.0 + 2048.0 * $sin(TWO_PI * real'(i) / 256.0);
    r = $rtoi(v + 0.5);
    if (r > 4095) r = 4095;
    if (r < 0) r = 0;
    return r;
  endfunction

  function automatic int exp_out(input logic [31:0] ph);
    int a, f, y0, y1, p, s;
    a  = int'(ph[31:24]);
    f  = int'(ph[23:16]);
    y0 = exp_rom(a);
    y1 = exp_rom((a + 1) % 256);
    p  = (y1 - y0) * f;
    s  = (p >= 0) ? p / 256 : -((-p + 255) / 256);
    return y0 + s;
  endfunction

  function automatic logic [31:0] exp_tw(input logic [3:0] sw);
    logic [63:0] t;
    t = 64'd1523800 * 64'(tenths[int'(~sw)]);
    return t[31:0];
  endfunction

  task automatic check(input string req, input int exp);
    checks = checks + 1;
    if (int'(sample_o) != exp) begin
      errors = errors + 1;
      $display("FAIL %s: sample_o %0d expected %0d", req, sample_o, exp);
    end
  endtask

  // strobe at edge N, read half a cycle after edge N+2
  task automatic strobe_and_check(input string req);
    @(negedge clk_i);
    strobe_i = 1'b1;
    model_ph = model_ph + exp_tw(sw_ni);
    @(negedge clk_i);
    strobe_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    last_exp = exp_out(model_ph);
    if (model_ph[31:24] == 8'hFF) begin
      hit_wrap = hit_wrap + 1;
      check("R9", last_exp);
    end else begin
      check(req, last_exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    strobe_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    model_ph = '0;
    last_exp = 2048;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", 2048);

    // R5 table walk across presets and phases
    for (int v = 0; v < 10; v++) begin
      sw_ni = VEC[v][11:8];
      for (int n = 0; n < int'(VEC[v][7:0]); n++) strobe_and_check("R5");
    end

    // R7: switch change between strobes leaves output and phase alone
    sw_ni = 4'h2;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk_i);
      check("R7", last_exp);
    end
    strobe_and_check("R7");
    strobe_and_check("R7");

    // R2: idle cycles hold the output
    for (int k = 0; k < 5; k++) begin
      @(negedge clk_i);
      check("R2", last_exp);
    end

    // R6: nothing appears after edge N+1, value appears after N+2
    @(negedge clk_i);
    strobe_i = 1'b1;
    model_ph = model_ph + exp_tw(sw_ni);
    @(negedge clk_i);
    strobe_i = 1'b0;
    check("R6", last_exp);
    @(negedge clk_i);
    check("R6", last_exp);
    @(negedge clk_i);
    last_exp = exp_out(model_ph);
    check("R6", last_exp);

    // R3: one strobe from zero phase for every preset
    for (int s = 0; s < 16; s++) begin
      do_reset();
      check("R1", 2048);
      sw_ni = 4'(~s);
      strobe_and_check("R3");
      strobe_and_check("R3");
    end

    // R4: back-to-back strobes every cycle, then check the final sample
    do_reset();
    sw_ni = 4'h0;
    @(negedge clk_i);
    strobe_i = 1'b1;
    for (int k = 0; k < 4; k++) begin
      model_ph = model_ph + exp_tw(sw_ni);
      @(negedge clk_i);
    end
    strobe_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R4", exp_out(model_ph));

    // R9 and R8: run the slowest preset until address 255 is reached
    do_reset();
    sw_ni = 4'hF;
    for (int k = 0; k < 20000 && hit_wrap < 2; k++) strobe_and_check("R8");
    checks = checks + 1;
    if (hit_wrap == 0) begin
      errors = errors + 1;
      $display("FAIL R9: wrap visits %0d expected %0d", hit_wrap, 1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule